// File: doc/BRIEF.md
# TDM Time-Slot Interchanger

The block reorders byte-wide time slots inside a TDM frame of 32 channels. Each slot strobe brings one input byte and sends out one output byte. A connection table, with one entry per output channel, names the input channel that feeds that output. The same input channel may be named by any number of entries.

Two delay modes are available. In variable mode a single data buffer keeps latency as short as the pipeline allows: three slots at least. Any route that the pipeline cannot meet in time moves to the next frame. In constant mode three data buffers rotate at each frame, so every byte taken in during frame N leaves in frame N+2, whatever route it takes.

Framing is handled by a two-state machine:
- SYNC_HUNT is entered at reset. In this state strobes are ignored.
- The transition HUNT→RUN fires on the first strobe that carries a frame pulse. That strobe is processed as channel 0.
- SYNC_RUN holds until reset.

The delay mode has two states, DLY_VARIABLE and DLY_CONSTANT. A mode write only sets a pending value, which is copied into the active mode at the next frame-pulse strobe.

Top module: `tsi_top`

## Requirements
- R1: After reset `dout` is 0, the framer is in SYNC_HUNT, and both the active and the pending mode are variable.
- R2: Until the first strobe that carries `frame_pulse`, strobes have no effect and `dout` stays 0.
- R3: `frame_pulse` with `slot_en` marks channel 0, and each frame has exactly 32 strobes. `dout` changes only at clock edges where `slot_en` is high. After the edge of the strobe for channel m, `dout` holds the byte of output channel m.
- R4: In variable mode, when output m is fed from input n with m ≥ n+3, the byte leaves in the same frame, m−n strobes after it entered. The shortest such delay is 3 strobes.
- R5: In variable mode, when m equals n, n+1 or n+2, the byte leaves in the next frame, m−n+32 strobes after it entered.
- R6: In variable mode, when m < n, the byte leaves in the next frame, 32−(n−m) strobes after it entered. For example, channel 30 routed to channel 1 leaves 3 strobes later.
- R7: In constant mode, output channel m in frame N+2 carries the byte that input channel n carried in frame N. That is 64+m−n strobes after it entered, or 63+m−n whole slots between the end of the input slot and the start of the output slot. The delay therefore ranges from 32 slots (31→0) to 94 slots (0→31).
- R8: A write with `mode_we` stores `mode_const` as the pending mode (1 = constant, 0 = variable). The pending mode becomes active at the next strobe carrying `frame_pulse`. The rest of the current frame is unaffected.
- R9: Writing `cm_src`=n at `cm_addr`=m makes output m take input n. The new entry is used by lookups made after the write, and it governs the whole frame after the next frame pulse.
- R10: One input channel may feed any number of output channels in the same frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_pulse | input | 1 | With `slot_en`, marks channel 0 of a frame |
| slot_en | input | 1 | Slot strobe, one per channel |
| din | input | WIDTH | Input byte for the current slot |
| dout | output | WIDTH | Output byte for the current slot |
| cm_we | input | 1 | Connection table write enable |
| cm_addr | input | CH_W | Output channel whose entry is written |
| cm_src | input | CH_W | Input channel to route to that output |
| mode_we | input | 1 | Pending mode write enable |
| mode_const | input | 1 | 1 selects constant delay, 0 selects variable |

## Verification
Each output byte is due on the clock edge of the strobe for its own output channel. The expected value follows from the routing table and the mode: the same frame, the previous frame (variable mode) or two frames back (constant mode). The bench therefore queues one expected byte per strobe and compares `dout` on the falling edge just after that strobe's rising edge. On idle cycles between strobes, it checks that `dout` has not moved. Frames in which a table write or mode switch leaves the pipeline or buffers holding data from before the change are queued but not compared, and checking resumes once the buffers hold only data written after the change.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

    localparam int BANKS = 3;

    typedef enum logic {
        SYNC_HUNT = 1'b0,
        SYNC_RUN  = 1'b1
    } sync_state_e;

    typedef enum logic {
        DLY_VARIABLE = 1'b0,
        DLY_CONSTANT = 1'b1
    } delay_mode_e;

endpackage

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem #(
    parameter  int CHANNELS = 32,
    localparam int CH_W     = $clog2(CHANNELS)
) (
    input  logic            clk,
    input  logic            wr_en,
    input  logic [CH_W-1:0] wr_addr,
    input  logic [CH_W-1:0] wr_src,
    input  logic [CH_W-1:0] rd_addr,
    output logic [CH_W-1:0] rd_src
);

    logic [CH_W-1:0] entry_q [CHANNELS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            entry_q[wr_addr] <= wr_src;
        end
    end

    assign rd_src = entry_q[rd_addr];

endmodule

// File: rtl/tsi_data_mem.sv
module tsi_data_mem
    import tsi_pkg::*;
#(
    parameter  int CHANNELS = 32,
    parameter  int WIDTH    = 8,
    localparam int CH_W     = $clog2(CHANNELS),
    localparam int DEPTH    = BANKS * CHANNELS,
    localparam int AW       = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [1:0]       wr_bank,
    input  logic [CH_W-1:0]  wr_ch,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [1:0]       rd_bank,
    input  logic [CH_W-1:0]  rd_ch,
    output logic [WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] store_q [DEPTH];

    function automatic logic [AW-1:0] flat_addr(input logic [1:0] bank, input logic [CH_W-1:0] ch);
        return AW'(bank) * AW'(CHANNELS) + AW'(ch);
    endfunction

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store_q[flat_addr(wr_bank, wr_ch)] <= wr_data;
        end
    end

    // Read returns the value held before any write on the same edge.
    assign rd_data = store_q[flat_addr(rd_bank, rd_ch)];

endmodule

// File: rtl/tsi_ctrl.sv
module tsi_ctrl
    import tsi_pkg::*;
#(
    parameter  int CHANNELS = 32,
    localparam int CH_W     = $clog2(CHANNELS),
    localparam int LOOKAHEAD = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_pulse,
    input  logic            slot_en,
    input  logic            mode_we,
    input  logic            mode_const,
    output logic            adv,
    output logic            running,
    output logic [CH_W-1:0] slot_now,
    output logic [CH_W-1:0] look_ch,
    output logic [1:0]      wr_bank,
    output logic [1:0]      rd_bank_cur,
    output logic [1:0]      rd_bank_nxt
);

    sync_state_e     state_q, state_d;
    delay_mode_e     mode_q, mode_pend_q, mode_now;
    logic [CH_W-1:0] slot_q;
    logic [1:0]      fcnt_q, fcnt_now;
    logic            sync_edge;

    function automatic logic [1:0] bank_inc(input logic [1:0] b);
        return (b == 2'(BANKS - 1)) ? 2'd0 : b + 2'd1;
    endfunction

    assign sync_edge = slot_en && frame_pulse;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SYNC_HUNT: state_d = sync_edge ? SYNC_RUN : SYNC_HUNT;
            SYNC_RUN:  state_d = SYNC_RUN;
            default:   state_d = SYNC_HUNT;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SYNC_HUNT;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs
    always_comb begin
        running = (state_q == SYNC_RUN);
        adv     = slot_en && (running || frame_pulse);
        if (frame_pulse || slot_q == CH_W'(CHANNELS - 1)) begin
            slot_now = '0;
        end else begin
            slot_now = slot_q + 1'b1;
        end
        look_ch  = CH_W'((int'(slot_now) + LOOKAHEAD) % CHANNELS);
        fcnt_now = sync_edge ? bank_inc(fcnt_q) : fcnt_q;
        mode_now = sync_edge ? mode_pend_q : mode_q;
        if (mode_now == DLY_CONSTANT) begin
            wr_bank     = fcnt_now;
            rd_bank_cur = bank_inc(fcnt_now);
            rd_bank_nxt = bank_inc(bank_inc(fcnt_now));
        end else begin
            wr_bank     = 2'd0;
            rd_bank_cur = 2'd0;
            rd_bank_nxt = 2'd0;
        end
    end

    // Slot, frame and mode registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q      <= CH_W'(CHANNELS - 1);
            fcnt_q      <= 2'd0;
            mode_q      <= DLY_VARIABLE;
            mode_pend_q <= DLY_VARIABLE;
        end else begin
            if (mode_we) begin
                mode_pend_q <= mode_const ? DLY_CONSTANT : DLY_VARIABLE;
            end
            if (adv) begin
                slot_q <= slot_now;
                fcnt_q <= fcnt_now;
                mode_q <= mode_now;
            end
        end
    end

    AST_FRAME_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        (running && slot_en) |-> (frame_pulse == (slot_q == CH_W'(CHANNELS - 1))))
        else $error("frame pulse out of place"); // R3

    AST_MODE_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_edge |=> $stable(mode_q))
        else $error("mode changed away from frame pulse"); // R8

endmodule

// File: rtl/tsi_top.sv
module tsi_top
    import tsi_pkg::*;
#(
    parameter  int CHANNELS = 32,
    parameter  int WIDTH    = 8,
    localparam int CH_W     = $clog2(CHANNELS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_pulse,
    input  logic             slot_en,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    input  logic             cm_we,
    input  logic [CH_W-1:0]  cm_addr,
    input  logic [CH_W-1:0]  cm_src,
    input  logic             mode_we,
    input  logic             mode_const
);

    logic             adv, running;
    logic [CH_W-1:0]  slot_now, look_ch, src_now, src_q, tgt_q;
    logic [1:0]       wr_bank, rd_bank_cur, rd_bank_nxt, rd_bank;
    logic [WIDTH-1:0] rd_data, rd_q, mid_q;

    tsi_ctrl #(.CHANNELS(CHANNELS)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_pulse (frame_pulse),
        .slot_en     (slot_en),
        .mode_we     (mode_we),
        .mode_const  (mode_const),
        .adv         (adv),
        .running     (running),
        .slot_now    (slot_now),
        .look_ch     (look_ch),
        .wr_bank     (wr_bank),
        .rd_bank_cur (rd_bank_cur),
        .rd_bank_nxt (rd_bank_nxt)
    );

    tsi_conn_mem #(.CHANNELS(CHANNELS)) u_cmem (
        .clk     (clk),
        .wr_en   (cm_we),
        .wr_addr (cm_addr),
        .wr_src  (cm_src),
        .rd_addr (look_ch),
        .rd_src  (src_now)
    );

    // The read targets the channel two strobes ahead; it belongs to the
    // next frame when that channel number has wrapped below the current slot.
    assign rd_bank = (tgt_q < slot_now) ? rd_bank_nxt : rd_bank_cur;

    tsi_data_mem #(.CHANNELS(CHANNELS), .WIDTH(WIDTH)) u_dmem (
        .clk     (clk),
        .wr_en   (adv),
        .wr_bank (wr_bank),
        .wr_ch   (slot_now),
        .wr_data (din),
        .rd_bank (rd_bank),
        .rd_ch   (src_q),
        .rd_data (rd_data)
    );

    // Lookup at slot s, read at s+1, hold at s+2, drive at s+3.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0;
            tgt_q <= '0;
            rd_q  <= '0;
            mid_q <= '0;
            dout  <= '0;
        end else if (adv) begin
            src_q <= src_now;
            tgt_q <= look_ch;
            rd_q  <= rd_data;
            mid_q <= rd_q;
            dout  <= mid_q;
        end
    end

    AST_DOUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_en |=> $stable(dout))
        else $error("output moved without a strobe"); // R3

    AST_HUNT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (dout == '0))
        else $error("output active before frame sync"); // R2

endmodule

// File: tb/tb_tsi_top.sv
module tb_tsi_top;

    localparam int CHANNELS = 32;
    localparam int WIDTH    = 8;
    localparam int CH_W     = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             frame_pulse = 1'b0;
    logic             slot_en = 1'b0;
    logic [WIDTH-1:0] din = '0;
    logic [WIDTH-1:0] dout;
    logic             cm_we = 1'b0;
    logic [CH_W-1:0]  cm_addr = '0;
    logic [CH_W-1:0]  cm_src = '0;
    logic             mode_we = 1'b0;
    logic             mode_const = 1'b0;

    always #4 clk = ~clk;

    tsi_top #(.CHANNELS(CHANNELS), .WIDTH(WIDTH)) dut (
        .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse), .slot_en(slot_en),
        .din(din), .dout(dout), .cm_we(cm_we), .cm_addr(cm_addr), .cm_src(cm_src),
        .mode_we(mode_we), .mode_const(mode_const)
    );

    int checks = 0;
    int errors = 0;

    logic [CH_W-1:0] cm_model [CHANNELS];
    bit  mode_eff = 1'b0;
    bit  mode_pend = 1'b0;
    bit  bcast = 1'b0;
    int  frame_no = -1;
    int  check_start = 1;
    int  cm_frame = 1;

    logic [WIDTH-1:0] exp_q [$];
    bit               chk_q [$];
    string            tag_q [$];

    bit               mon_strobe;
    bit               idle_on = 1'b0;
    logic [WIDTH-1:0] last_dout;
    logic [WIDTH-1:0] m_exp;
    bit               m_chk;
    string            m_tag;

    task automatic check(input bit ok, input string req, input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", req, act, exp);
        end
    endtask

    function automatic logic [WIDTH-1:0] in_byte(input int f, input int ch);
        return {3'(f), 5'(ch)};
    endfunction

    function automatic logic [WIDTH-1:0] expected(input int f, input int m);
        int n;
        int sf;
        n = int'(cm_model[m]);
        if (mode_eff) sf = f - 2;
        else if (m >= n + 3) sf = f;
        else sf = f - 1;
        return in_byte(sf, n);
    endfunction

    function automatic string classify(input int m);
        int n;
        n = int'(cm_model[m]);
        if (mode_eff) return "R7";
        if (m > n + 2) return "R4";
        if (m >= n) return "R5";
        return "R6";
    endfunction

    // Monitor: one queued item per strobe; stability check on idle cycles.
    initial begin
        forever begin
            @(posedge clk);
            mon_strobe = slot_en;
            @(negedge clk);
            if (rst_n) begin
                if (mon_strobe) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R3 queue empty", dout, '0);
                    end else begin
                        m_exp = exp_q.pop_front();
                        m_chk = chk_q.pop_front();
                        m_tag = tag_q.pop_front();
                        if (m_chk) check(dout === m_exp, m_tag, dout, m_exp);
                    end
                end else if (idle_on) begin
                    check(dout === last_dout, "R3 idle", dout, last_dout);
                end
                last_dout = dout;
            end
        end
    end

    task automatic strobe(input bit fp, input logic [WIDTH-1:0] data, input bit chk,
                          input logic [WIDTH-1:0] exp, input string tag);
        @(negedge clk);
        slot_en     = 1'b1;
        frame_pulse = fp;
        din         = data;
        exp_q.push_back(exp);
        chk_q.push_back(chk);
        tag_q.push_back(tag);
        @(negedge clk);
        slot_en     = 1'b0;
        frame_pulse = 1'b0;
    endtask

    // R9: load a routing pattern between frames
    task automatic load_cm(input int pat);
        for (int m = 0; m < CHANNELS; m++) begin
            int n;
            case (pat)
                0:       n = (m + 29) % CHANNELS;
                1:       n = m;
                2:       n = (m * 5 + 11) % CHANNELS;
                default: n = 7;
            endcase
            @(negedge clk);
            cm_we       = 1'b1;
            cm_addr     = CH_W'(m);
            cm_src      = CH_W'(n);
            cm_model[m] = CH_W'(n);
        end
        @(negedge clk);
        cm_we = 1'b0;
        bcast = (pat == 3);
        cm_frame = frame_no + 2;
        if (check_start < cm_frame) check_start = cm_frame;
    endtask

    task automatic run_frame(input int mode_slot, input bit mode_val);
        frame_no++;
        if (mode_pend != mode_eff) begin
            mode_eff = mode_pend;
            if (check_start < frame_no + (mode_eff ? 2 : 1)) check_start = frame_no + (mode_eff ? 2 : 1);
        end
        for (int ch = 0; ch < CHANNELS; ch++) begin
            logic [WIDTH-1:0] e;
            bit               c;
            string            t;
            e = expected(frame_no, ch);
            c = (frame_no >= check_start);
            t = classify(ch);
            if (bcast) t = {t, " R10"};
            if (frame_no == cm_frame) t = {t, " R9"};
            if (frame_no == 1) t = {t, " R1"};
            if (mode_slot >= 0 && ch > mode_slot) t = {t, " R8"};
            strobe(ch == 0, in_byte(frame_no, ch), c, e, t);
            if (ch == mode_slot) begin
                @(negedge clk);
                mode_we    = 1'b1;
                mode_const = mode_val;
                @(negedge clk);
                mode_we    = 1'b0;
                mode_pend  = mode_val;
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", '0, '0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(dout === '0, "R1 reset", dout, '0);
        last_dout = dout;
        idle_on = 1'b1;

        // R2: strobes before any frame pulse are ignored
        for (int i = 0; i < 4; i++) strobe(1'b0, 8'hA5 + 8'(i), 1'b1, '0, "R2");

        load_cm(0);                       // n = m-3: R4 and R6 (30->1)
        for (int i = 0; i < 3; i++) run_frame(-1, 1'b0);
        load_cm(1);                       // n = m: R5
        for (int i = 0; i < 3; i++) run_frame(-1, 1'b0);
        load_cm(2);                       // mixed routes
        for (int i = 0; i < 3; i++) run_frame(-1, 1'b0);
        load_cm(3);                       // broadcast of channel 7
        for (int i = 0; i < 2; i++) run_frame(-1, 1'b0);
        run_frame(10, 1'b1);              // R8: switch to constant mid-frame
        for (int i = 0; i < 4; i++) run_frame(-1, 1'b0);
        load_cm(2);
        for (int i = 0; i < 3; i++) run_frame(-1, 1'b0);
        run_frame(20, 1'b0);              // R8: back to variable
        for (int i = 0; i < 3; i++) run_frame(-1, 1'b0);

        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule